// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block is the timekeeping core of a real-time clock. It holds seven BCD bytes: seconds, minutes, hours, day of week, day of month, month and a two-digit year for 2000 to 2099. An internal prescaler counts oscillator pulses. One full second of them advances the time by one second, and carries ripple up through the calendar: month lengths are taken into account, and February gets 29 days in years divisible by four.

The hour byte can run in either of two formats, selected by a flag in that same byte. In 24-hour format the hour counts 00 to 23. In 12-hour format bit 6 is set, bit 5 marks the afternoon, and the BCD hour counts 12, 01 .. 11. A register port lets any field be loaded with a byte write and read back combinationally. A write to a field restarts the sub-second phase. An oscillator-stop input freezes both the time and the prescaler. Each time the seconds count advances, the block emits a single-cycle pulse for a downstream alarm comparator.

Top module: `bcd_clock_core`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00 (24-hour), day of week 0x01, day of month 0x01, month 0x01 and year 0x00.
- R2: `rdata_o` shows the field selected by `addr_i` in the same cycle: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year; address 7 reads 0x00.
- R3: A cycle with `wr_en_i` high and `addr_i` from 0 to 6 stores `wdata_i` unchanged into that field. A write to address 7 changes nothing.
- R4: The seconds advance once for every TICKS_PER_SEC cycles that have `osc_tick_i` high while running. `sec_pulse_o` is high for exactly the one cycle after each advance.
- R5: While `osc_off_i` is 1, no field advances, the prescaler holds its count and `sec_pulse_o` stays low.
- R6: A write to any field clears the prescaler, so a full TICKS_PER_SEC further ticks are needed before the next advance. A write in the same cycle as the tick that would complete a second takes priority, and that advance is dropped.
- R7: Seconds and minutes count in BCD from 00 to 59. Stepping from 59 wraps to 00 and carries into the next field.
- R8: In 24-hour format (hour bit 6 clear) the hour steps from 23 to 00 and carries into the date.
- R9: In 12-hour format (hour bit 6 set, bit 5 = PM) 11 steps to 12 with bit 5 inverted, and 12 steps to 01 with bit 5 kept. Only the step from 11 PM to 12 AM carries into the date.
- R10: On a date carry the day of week steps from 1 to 7 and then wraps from 7 to 1.
- R11: On a date carry the day of month wraps to 01 after the last day of its month. That is 30 for months 04, 06, 09 and 11, 31 for the other months, and for month 02 it is 29 when the year value is divisible by four and 28 otherwise.
- R12: Wrapping the day of month steps the month from 12 to 01. The step from 12 to 01 also steps the year, which runs from 99 to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick_i | input | 1 | One-cycle pulse per oscillator period |
| osc_off_i | input | 1 | 1 stops the oscillator: time and prescaler hold |
| wr_en_i | input | 1 | Byte write strobe |
| addr_i | input | 3 | Field select for both read and write |
| wdata_i | input | 8 | Byte to store |
| rdata_o | output | 8 | Selected field, combinational |
| sec_pulse_o | output | 1 | One-cycle pulse after each seconds advance |

## Verification
The bench aims at the rollover seams. It steps 23:59:59 on 31 December of year 99, and a design with a broken carry chain would leave one field behind, for example the year not wrapping or the day of week reaching 8. It walks the three 12-hour steps, where a wrong design inverts PM on 12 to 1 or advances the date at noon. It ends 30-day months, and ends February in a leap and a common year, which catches a design that uses 31 days everywhere or gets the BCD divisibility test wrong. A write landing on the completing tick, and a write in mid-second, show whether the prescaler really restarts: a design that kept the old phase would advance the seconds too early.

// File: rtl/bcd_clk_pkg.sv
package bcd_clk_pkg;

    localparam int NUM_FIELDS = 7;
    localparam int ADDR_W     = 3;

    typedef enum logic [ADDR_W-1:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_WDAY = 3'd3,
        FLD_MDAY = 3'd4,
        FLD_MON  = 3'd5,
        FLD_YEAR = 3'd6
    } field_e;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] mon;
        logic [7:0] year;
    } cal_t;

    typedef struct packed {
        cal_t t;
        logic pulse;
    } core_t;

    // Two-digit BCD increment without range wrap.
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last valid BCD day of a BCD month in a given BCD year.
    function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] year);
        logic [7:0] ybin;
        ybin = 8'(year[7:4]) * 8'd10 + 8'(year[3:0]);
        case (mon)
            8'h02:                   return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                 return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_clk_prescaler.sv
module bcd_clk_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick_i,
    input  logic run_i,
    input  logic restart_i,
    output logic sec_strobe_o
);
    localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d        = cnt_q;
        sec_strobe_o = 1'b0;
        if (restart_i) begin
            cnt_d = '0;
        end else if (run_i && osc_tick_i) begin
            if (cnt_q == LAST) begin
                cnt_d        = '0;
                sec_strobe_o = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bcd_clk_hour_step.sv
module bcd_clk_hour_step (
    input  logic [7:0] hour_i,
    output logic [7:0] hour_o,
    output logic       day_carry_o
);
    import bcd_clk_pkg::*;

    logic [7:0] stepped;

    always_comb begin
        stepped     = bcd_step({3'b000, hour_i[4:0]});
        hour_o      = hour_i;
        day_carry_o = 1'b0;
        if (hour_i[6]) begin
            // 12-hour format: 12, 01 .. 11, PM flag in bit 5
            if (hour_i[4:0] >= 5'h12) begin
                hour_o = {hour_i[7:5], 5'h01};
            end else if (hour_i[4:0] == 5'h11) begin
                hour_o      = {hour_i[7:6], ~hour_i[5], 5'h12};
                day_carry_o = hour_i[5];
            end else begin
                hour_o = {hour_i[7:5], stepped[4:0]};
            end
        end else begin
            if (hour_i[5:0] >= 6'h23) begin
                hour_o      = {hour_i[7:6], 6'h00};
                day_carry_o = 1'b1;
            end else begin
                stepped = bcd_step({2'b00, hour_i[5:0]});
                hour_o  = {hour_i[7:6], stepped[5:0]};
            end
        end
    end
endmodule

// File: rtl/bcd_clk_date_step.sv
module bcd_clk_date_step (
    input  logic       carry_i,
    input  logic [7:0] wday_i,
    input  logic [7:0] mday_i,
    input  logic [7:0] mon_i,
    input  logic [7:0] year_i,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o
);
    import bcd_clk_pkg::*;

    always_comb begin
        wday_o = wday_i;
        mday_o = mday_i;
        mon_o  = mon_i;
        year_o = year_i;
        if (carry_i) begin
            wday_o = (wday_i >= 8'd7 || wday_i == 8'd0) ? 8'd1 : wday_i + 8'd1;
            if (mday_i >= last_day(mon_i, year_i)) begin
                mday_o = 8'h01;
                if (mon_i >= 8'h12) begin
                    mon_o  = 8'h01;
                    year_o = (year_i >= 8'h99) ? 8'h00 : bcd_step(year_i);
                end else begin
                    mon_o = bcd_step(mon_i);
                end
            end else begin
                mday_o = bcd_step(mday_i);
            end
        end
    end
endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick_i,
    input  logic       osc_off_i,
    input  logic       wr_en_i,
    input  logic [2:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       sec_pulse_o
);
    import bcd_clk_pkg::*;

    localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h01,
                                   mday: 8'h01, mon: 8'h01, year: 8'h00};

    core_t state_d, state_q;

    logic       wr_hit;
    logic       sec_strobe;
    logic       sec_wrap, min_wrap;
    logic [7:0] hour_next;
    logic       hour_carry;
    logic       date_carry;
    logic [7:0] wday_next, mday_next, mon_next, year_next;

    assign wr_hit     = wr_en_i && (int'(addr_i) < NUM_FIELDS);
    assign sec_wrap   = state_q.t.sec >= 8'h59;
    assign min_wrap   = state_q.t.min >= 8'h59;
    assign date_carry = sec_wrap && min_wrap && hour_carry;

    bcd_clk_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_tick_i  (osc_tick_i),
        .run_i       (!osc_off_i),
        .restart_i   (wr_hit),
        .sec_strobe_o(sec_strobe)
    );

    bcd_clk_hour_step u_hour (
        .hour_i     (state_q.t.hour),
        .hour_o     (hour_next),
        .day_carry_o(hour_carry)
    );

    bcd_clk_date_step u_date (
        .carry_i(date_carry),
        .wday_i (state_q.t.wday),
        .mday_i (state_q.t.mday),
        .mon_i  (state_q.t.mon),
        .year_i (state_q.t.year),
        .wday_o (wday_next),
        .mday_o (mday_next),
        .mon_o  (mon_next),
        .year_o (year_next)
    );

    always_comb begin
        state_d       = state_q;
        state_d.pulse = 1'b0;
        if (wr_hit) begin
            case (field_e'(addr_i))
                FLD_SEC:  state_d.t.sec  = wdata_i;
                FLD_MIN:  state_d.t.min  = wdata_i;
                FLD_HOUR: state_d.t.hour = wdata_i;
                FLD_WDAY: state_d.t.wday = wdata_i;
                FLD_MDAY: state_d.t.mday = wdata_i;
                FLD_MON:  state_d.t.mon  = wdata_i;
                default:  state_d.t.year = wdata_i;
            endcase
        end else if (sec_strobe) begin
            state_d.pulse = 1'b1;
            state_d.t.sec = sec_wrap ? 8'h00 : bcd_step(state_q.t.sec);
            if (sec_wrap) begin
                state_d.t.min = min_wrap ? 8'h00 : bcd_step(state_q.t.min);
                if (min_wrap) state_d.t.hour = hour_next;
            end
            state_d.t.wday = wday_next;
            state_d.t.mday = mday_next;
            state_d.t.mon  = mon_next;
            state_d.t.year = year_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{t: CAL_RESET, pulse: 1'b0};
        else        state_q <= state_d;
    end

    always_comb begin
        case (addr_i)
            3'd0:    rdata_o = state_q.t.sec;
            3'd1:    rdata_o = state_q.t.min;
            3'd2:    rdata_o = state_q.t.hour;
            3'd3:    rdata_o = state_q.t.wday;
            3'd4:    rdata_o = state_q.t.mday;
            3'd5:    rdata_o = state_q.t.mon;
            3'd6:    rdata_o = state_q.t.year;
            default: rdata_o = 8'h00;
        endcase
    end

    assign sec_pulse_o = state_q.pulse;
endmodule

// File: rtl/bcd_clock_core_sva.sv
module bcd_clock_core_sva (
    input logic               clk,
    input logic               rst_n,
    input logic               osc_off_i,
    input logic               wr_en_i,
    input logic [2:0]         addr_i,
    input logic [7:0]         wdata_i,
    input logic               sec_pulse_o,
    input bcd_clk_pkg::core_t state_q
);
    assert_stop_holds_sec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_off_i && !wr_en_i) |=> $stable(state_q.t.sec));

    assert_stop_no_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        osc_off_i |=> !sec_pulse_o);

    assert_pulse_marks_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse_o |-> (state_q.t.sec != $past(state_q.t.sec)));

    assert_sec_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse_o |-> (state_q.t.sec[3:0] <= 4'd9 && state_q.t.sec <= 8'h59));

    assert_write_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 3'd0) |=> (state_q.t.sec == $past(wdata_i)));

    assert_wday_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse_o && $past(state_q.t.wday) >= 8'd1 && $past(state_q.t.wday) <= 8'd7)
        |-> (state_q.t.wday >= 8'd1 && state_q.t.wday <= 8'd7));
endmodule

bind bcd_clock_core bcd_clock_core_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_off_i  (osc_off_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .sec_pulse_o(sec_pulse_o),
    .state_q    (state_q)
);

// File: tb/bcd_clock_core_tb.sv
module bcd_clock_core_tb;
    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick_i = 1'b0;
    logic       osc_off_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] addr_i = 3'd0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic       sec_pulse_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_clock_core #(.TICKS_PER_SEC(TPS)) u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick_i(osc_tick_i), .osc_off_i(osc_off_i),
        .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .sec_pulse_o(sec_pulse_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr_i = a;
        #1;
        check(req, int'(rdata_o), int'(exp));
    endtask

    task automatic tick(output bit seen);
        @(negedge clk);
        osc_tick_i = 1'b1;
        @(negedge clk);
        osc_tick_i = 1'b0;
        seen = sec_pulse_o;
    endtask

    // n ticks, returns number of pulses seen
    task automatic ticks(input int n, output int pulses);
        bit s;
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            tick(s);
            if (s) pulses++;
        end
    endtask

    task automatic set_all(input logic [7:0] s, m, h, wd, md, mo, y);
        wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, wd);
        wr(3'd4, md); wr(3'd5, mo); wr(3'd6, y);
    endtask

    task automatic t_reset;
        expect_reg("R1 sec", 3'd0, 8'h00);
        expect_reg("R1 min", 3'd1, 8'h00);
        expect_reg("R1 hour", 3'd2, 8'h00);
        expect_reg("R1 wday", 3'd3, 8'h01);
        expect_reg("R1 mday", 3'd4, 8'h01);
        expect_reg("R1 mon", 3'd5, 8'h01);
        expect_reg("R1 year", 3'd6, 8'h00);
        check("R1 pulse", int'(sec_pulse_o), 0);
        expect_reg("R2 addr7", 3'd7, 8'h00);
    endtask

    task automatic t_write_read;
        set_all(8'h12, 8'h34, 8'h15, 8'h05, 8'h27, 8'h08, 8'h42);
        wr(3'd7, 8'h55);
        expect_reg("R3 sec", 3'd0, 8'h12);
        expect_reg("R3 min", 3'd1, 8'h34);
        expect_reg("R3 hour", 3'd2, 8'h15);
        expect_reg("R3 wday", 3'd3, 8'h05);
        expect_reg("R3 mday", 3'd4, 8'h27);
        expect_reg("R2 mon", 3'd5, 8'h08);
        expect_reg("R2 year", 3'd6, 8'h42);
        expect_reg("R3 addr7 write ignored", 3'd7, 8'h00);
    endtask

    task automatic t_advance;
        int p;
        wr(3'd0, 8'h08);
        ticks(TPS - 1, p);
        check("R4 no early pulse", p, 0);
        expect_reg("R4 sec held", 3'd0, 8'h08);
        ticks(1, p);
        check("R4 one pulse", p, 1);
        @(negedge clk);
        check("R4 pulse one cycle", int'(sec_pulse_o), 0);
        expect_reg("R4 sec step", 3'd0, 8'h09);
        ticks(TPS, p);
        expect_reg("R7 bcd digit carry", 3'd0, 8'h10);
    endtask

    task automatic t_stop;
        int p;
        wr(3'd0, 8'h10);
        osc_off_i = 1'b1;
        ticks(2 * TPS, p);
        check("R5 no pulse while stopped", p, 0);
        expect_reg("R5 sec frozen", 3'd0, 8'h10);
        osc_off_i = 1'b0;
        ticks(TPS - 1, p);
        expect_reg("R5 prescaler held", 3'd0, 8'h10);
        ticks(1, p);
        expect_reg("R5 resumes", 3'd0, 8'h11);
    endtask

    task automatic t_phase;
        int p;
        wr(3'd0, 8'h20);
        ticks(TPS - 1, p);
        wr(3'd1, 8'h05);
        ticks(TPS - 1, p);
        check("R6 phase restart no pulse", p, 0);
        expect_reg("R6 phase restart sec", 3'd0, 8'h20);
        ticks(1, p);
        expect_reg("R6 full second later", 3'd0, 8'h21);
        // write coinciding with completing tick
        ticks(TPS - 1, p);
        @(negedge clk);
        osc_tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 3'd0; wdata_i = 8'h30;
        @(negedge clk);
        osc_tick_i = 1'b0; wr_en_i = 1'b0;
        check("R6 write wins no pulse", int'(sec_pulse_o), 0);
        expect_reg("R6 write wins value", 3'd0, 8'h30);
        ticks(TPS - 1, p);
        expect_reg("R6 after collision held", 3'd0, 8'h30);
        ticks(1, p);
        expect_reg("R6 after collision step", 3'd0, 8'h31);
    endtask

    task automatic t_year_end;
        int p;
        set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        ticks(TPS, p);
        expect_reg("R7 sec wrap", 3'd0, 8'h00);
        expect_reg("R7 min wrap", 3'd1, 8'h00);
        expect_reg("R8 hour wrap", 3'd2, 8'h00);
        expect_reg("R10 wday wrap", 3'd3, 8'h01);
        expect_reg("R11 mday wrap", 3'd4, 8'h01);
        expect_reg("R12 mon wrap", 3'd5, 8'h01);
        expect_reg("R12 year wrap", 3'd6, 8'h00);
    endtask

    task automatic t_twelve_hour;
        int p;
        set_all(8'h59, 8'h59, 8'h51, 8'h02, 8'h05, 8'h03, 8'h21);
        ticks(TPS, p);
        expect_reg("R9 11AM to 12PM", 3'd2, 8'h72);
        expect_reg("R9 noon no date carry", 3'd4, 8'h05);
        wr(3'd0, 8'h59); wr(3'd1, 8'h59);
        ticks(TPS, p);
        expect_reg("R9 12PM to 1PM", 3'd2, 8'h61);
        wr(3'd2, 8'h71); wr(3'd0, 8'h59); wr(3'd1, 8'h59);
        ticks(TPS, p);
        expect_reg("R9 11PM to 12AM", 3'd2, 8'h52);
        expect_reg("R9 midnight date carry", 3'd4, 8'h06);
        expect_reg("R10 wday step", 3'd3, 8'h03);
    endtask

    task automatic t_month_len;
        int p;
        set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23);
        ticks(TPS, p);
        expect_reg("R11 30-day end mday", 3'd4, 8'h01);
        expect_reg("R11 30-day end mon", 3'd5, 8'h05);
        set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h05, 8'h23);
        ticks(TPS, p);
        expect_reg("R11 31-day month", 3'd4, 8'h31);
        set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
        ticks(TPS, p);
        expect_reg("R11 common Feb mday", 3'd4, 8'h01);
        expect_reg("R11 common Feb mon", 3'd5, 8'h03);
        set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
        ticks(TPS, p);
        expect_reg("R11 leap Feb 29", 3'd4, 8'h29);
        wr(3'd0, 8'h59); wr(3'd1, 8'h59); wr(3'd2, 8'h23);
        ticks(TPS, p);
        expect_reg("R11 leap Feb end mday", 3'd4, 8'h01);
        expect_reg("R12 month step", 3'd5, 8'h03);
        expect_reg("R12 year held", 3'd6, 8'h24);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_advance();
        t_stop();
        t_phase();
        t_year_end();
        t_twelve_hour();
        t_month_len();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule